// File: doc/BRIEF.md
# Graphics RAM Host Port with Read Latch

This block is the host-side path into a pixel RAM with 16-bit words, accessed over a parallel register interface. An access strobe, a register-select line and a read/write line are sampled on each clock edge. With register-select low, a write loads an 8-bit index register. With register-select high, a write goes to the register the index selects. Those registers are an entry-mode register, two window-bound registers, the address register and the RAM data port. The address counter holds a column and a row. After each RAM data write it moves on by itself inside a rectangular window, in a direction set by the entry mode.

Reads of the RAM data port go through a one-word read latch. The first read after the address is set, or after a RAM write, is a dummy: the bus returns zero and the addressed word is copied into the latch. The next read returns that word and loads the latch again from the same address. Reads never move the address. A host can therefore run a logical operation on a pixel with this sequence: set the address, dummy read, read, then write. The write lands on the pixel that was read, and the counter then advances.

The RAM size is set by parameters. A full panel is 132 columns by 176 rows. The default build is smaller.

Top module: `gram_host_port`

## Requirements
- R1: A write with rs=0 loads the index register from din[7:0]; the index selects the target of later rs=1 accesses.
- R2: With rs=1 and rw=0, index 0x03 loads the mode bits: bit0 am, bit1 horizontal increment, bit2 vertical increment. Index 0x44 loads the horizontal window as {end[15:8], start[7:0]}. Index 0x45 loads the vertical window the same way. Index 0x21 loads the address as {row[15:8], col[7:0]}.
- R3: A write with rs=1 to index 0x22 stores din at the current (row, col) and then advances the address.
- R4: The first read of index 0x22 after an address load, a RAM write or reset drives dout to 0 one cycle later. It copies the addressed word into the latch and leaves the address unchanged.
- R5: Each further read of index 0x22 drives dout to the latched word one cycle later, reloads the latch from the current address and leaves the address unchanged.
- R6: With am=0, the column steps first. When the column passes its window edge, it restarts at the opposite horizontal bound and the row steps once.
- R7: With am=1, the row steps first. When the row passes its window edge, it restarts at the opposite vertical bound and the column steps once.
- R8: Increment bits at 0 make the counter step downward. Leaving the last window corner, in either direction, wraps the address to the first corner.
- R9: A read with rs=0, or a read of any index other than 0x22, drives dout to 0.
- R10: After reset the index is 0, am=0, both increment bits are 1, the window covers the whole RAM, the address is (0,0), dout is 0 and the latch is stale.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| acc | input | 1 | Access strobe, one access per cycle it is high |
| rs | input | 1 | Register select: 0 index, 1 register/data |
| rw | input | 1 | 1 read, 0 write |
| din | input | 16 | Write data bus |
| dout | output | 16 | Read data, valid the cycle after a read |

## Verification
Writes are run into a small window in all three movement patterns: am=0 rising, am=1 rising, and am=0 falling. Each pattern places words at positions that differ only if the wrap goes to the correct bound and the line steps the correct way. Reading them back after a new address load then distinguishes a correct walk from an off-by-one or mirrored one. Runs of reads after an address load, and a read placed right after a read-then-write sequence, show whether the dummy read is inserted and whether reads leave the address in place.

// File: rtl/gram_host_port.sv
module gram_host_port #(
  parameter int COLS = 44,
  parameter int ROWS = 48,
  parameter int DW   = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          acc,
  input  logic          rs,
  input  logic          rw,
  input  logic [15:0]   din,
  output logic [DW-1:0] dout
);
  localparam int DEPTH = COLS * ROWS;
  localparam int AW    = $clog2(DEPTH);

  logic [7:0]    idx, hs, he, vs, ve, col, row;
  logic          am, inc_h, inc_v, stale;
  logic [DW-1:0] latch;
  logic [DW-1:0] mem [DEPTH];

  wire wr      = acc & ~rw;
  wire rd      = acc & rw;
  wire ram_sel = rs && idx == 8'h22;
  wire [AW-1:0] ptr = AW'(32'(row) * COLS + 32'(col));

  logic       h_hit, v_hit;
  logic [7:0] h_nx, v_nx, ncol, nrow;

  always_comb begin
    h_hit = inc_h ? (col == he) : (col == hs);
    v_hit = inc_v ? (row == ve) : (row == vs);
    h_nx  = inc_h ? (h_hit ? hs : col + 8'd1) : (h_hit ? he : col - 8'd1);
    v_nx  = inc_v ? (v_hit ? vs : row + 8'd1) : (v_hit ? ve : row - 8'd1);
    if (!am) begin
      ncol = h_nx;
      nrow = h_hit ? v_nx : row;
    end else begin
      nrow = v_nx;
      ncol = v_hit ? h_nx : col;
    end
  end

  always_ff @(posedge clk)
    if (wr && ram_sel) mem[ptr] <= din[DW-1:0];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      idx   <= 8'h00;
      am    <= 1'b0;
      inc_h <= 1'b1;
      inc_v <= 1'b1;
      hs    <= 8'd0;
      he    <= 8'(COLS - 1);
      vs    <= 8'd0;
      ve    <= 8'(ROWS - 1);
      col   <= 8'd0;
      row   <= 8'd0;
      stale <= 1'b1;
      latch <= '0;
      dout  <= '0;
    end else if (wr && !rs) begin
      idx <= din[7:0];
    end else if (wr) begin
      case (idx)
        8'h03: {inc_v, inc_h, am} <= din[2:0];
        8'h44: {he, hs} <= din;
        8'h45: {ve, vs} <= din;
        8'h21: begin
          {row, col} <= din;
          stale      <= 1'b1;
        end
        8'h22: begin
          col   <= ncol;
          row   <= nrow;
          stale <= 1'b1;
        end
        default: ;
      endcase
    end else if (rd) begin
      if (ram_sel) begin
        dout  <= stale ? '0 : latch;
        latch <= mem[ptr];
        stale <= 1'b0;
      end else begin
        dout <= '0;
      end
    end
  end
endmodule

module gram_host_port_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        acc,
  input logic        rs,
  input logic        rw,
  input logic [15:0] din,
  input logic [15:0] dout,
  input logic [7:0]  idx,
  input logic [7:0]  col,
  input logic [7:0]  row,
  input logic [7:0]  hs,
  input logic [7:0]  he,
  input logic [7:0]  vs,
  input logic [7:0]  ve,
  input logic        stale
);
  wire ram_rd = acc && rw && rs && idx == 8'h22;
  wire ram_wr = acc && !rw && rs && idx == 8'h22;
  wire in_win = col >= hs && col <= he && row >= vs && row <= ve;
  wire win_ok = hs <= he && vs <= ve;

  // R1
  index_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
    acc && !rw && !rs |=> idx == $past(din[7:0]));
  // R4
  dummy_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ram_rd && stale |=> dout == 16'h0000);
  // R4
  addr_stale_chk: assert property (@(posedge clk) disable iff (!rst_n)
    acc && !rw && rs && idx == 8'h21 |=> stale);
  // R5
  read_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ram_rd |=> $stable(col) && $stable(row) && !stale);
  // R6
  stay_in_win_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ram_wr && in_win && win_ok |=> in_win);
  // R9
  other_rd_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    acc && rw && !(rs && idx == 8'h22) |=> dout == 16'h0000);
endmodule

bind gram_host_port gram_host_port_chk u_chk (.*);

// File: tb/tb_gram_host_port.sv
module tb_gram_host_port;
  localparam int CLK_PERIOD = 10;
  localparam int N = 57;
  // entry: {kind[1:0], data[15:0], expected[15:0]}; kind 0 index write, 1 data write, 2 read + check
  localparam logic [33:0] TBL [N] = '{
    {2'd0,16'h0044,16'h0}, {2'd1,16'h0302,16'h0},
    {2'd0,16'h0045,16'h0}, {2'd1,16'h0201,16'h0},
    {2'd0,16'h0021,16'h0}, {2'd1,16'h0102,16'h0},
    {2'd0,16'h0022,16'h0},
    {2'd1,16'hA001,16'h0}, {2'd1,16'hA002,16'h0}, {2'd1,16'hA003,16'h0},
    {2'd1,16'hA004,16'h0}, {2'd1,16'hA005,16'h0},
    {2'd0,16'h0021,16'h0}, {2'd1,16'h0203,16'h0}, {2'd0,16'h0022,16'h0},
    {2'd2,16'h0,16'h0000}, {2'd2,16'h0,16'hA004}, {2'd2,16'h0,16'hA004},
    {2'd1,16'hB004,16'h0},
    {2'd2,16'h0,16'h0000}, {2'd2,16'h0,16'hA005},
    {2'd0,16'h0003,16'h0}, {2'd1,16'h0007,16'h0},
    {2'd0,16'h0021,16'h0}, {2'd1,16'h0102,16'h0}, {2'd0,16'h0022,16'h0},
    {2'd1,16'hC001,16'h0}, {2'd1,16'hC002,16'h0}, {2'd1,16'hC003,16'h0},
    {2'd1,16'hC004,16'h0},
    {2'd0,16'h0021,16'h0}, {2'd1,16'h0103,16'h0}, {2'd0,16'h0022,16'h0},
    {2'd2,16'h0,16'h0000}, {2'd2,16'h0,16'hC003},
    {2'd0,16'h0021,16'h0}, {2'd1,16'h0202,16'h0}, {2'd0,16'h0022,16'h0},
    {2'd2,16'h0,16'h0000}, {2'd2,16'h0,16'hC002},
    {2'd0,16'h0003,16'h0}, {2'd1,16'h0000,16'h0},
    {2'd0,16'h0021,16'h0}, {2'd1,16'h0102,16'h0}, {2'd0,16'h0022,16'h0},
    {2'd1,16'hD001,16'h0}, {2'd1,16'hD002,16'h0},
    {2'd0,16'h0021,16'h0}, {2'd1,16'h0203,16'h0}, {2'd0,16'h0022,16'h0},
    {2'd2,16'h0,16'h0000}, {2'd2,16'h0,16'hD002},
    {2'd0,16'h0021,16'h0}, {2'd1,16'h0102,16'h0}, {2'd0,16'h0022,16'h0},
    {2'd2,16'h0,16'h0000}, {2'd2,16'h0,16'hD001}
  };

  logic clk = 0, rst_n = 0, acc = 0, rs = 0, rw = 0;
  logic [15:0] din = 0, dout;
  int total = 0, bad = 0;
  bit done = 0;

  gram_host_port dut (.clk(clk), .rst_n(rst_n), .acc(acc), .rs(rs), .rw(rw), .din(din), .dout(dout));

  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic check(string req, logic [15:0] exp);
    total++;
    if (dout !== exp) begin
      bad++;
      $display("FAIL %s: dout=%h expected=%h", req, dout, exp);
    end
  endtask

  task automatic access(logic r_s, logic r_w, logic [15:0] d);
    @(negedge clk);
    acc = 1; rs = r_s; rw = r_w; din = d;
    @(negedge clk);
    acc = 0;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog: dout=%h expected=run end", dout);
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    check("R10 reset dout", 16'h0000);
    rst_n = 1;
    access(0, 0, 16'h0022);
    access(1, 1, 16'h0);
    check("R10 stale latch after reset", 16'h0000);
    // R1 R2 R3: default full window, address load through index 0x21
    access(0, 0, 16'h0021); access(1, 0, 16'h0005);
    access(0, 0, 16'h0022); access(1, 0, 16'hE001);
    access(0, 0, 16'h0021); access(1, 0, 16'h0005);
    access(0, 0, 16'h0022);
    access(1, 1, 16'h0); check("R4 dummy", 16'h0000);
    access(1, 1, 16'h0); check("R1 R2 R3 write then read", 16'hE001);
    // R9
    access(0, 0, 16'h0003);
    access(1, 1, 16'h0); check("R9 other index read", 16'h0000);
    access(0, 1, 16'h0); check("R9 rs=0 read", 16'h0000);
    for (int i = 0; i < N; i++) begin
      logic [1:0] k = TBL[i][33:32];
      string tag;
      if (TBL[i][15:0] == 16'h0) tag = "R4 dummy";
      else if (i <= 20) tag = "R3 R5 R6";
      else if (i <= 39) tag = "R7";
      else tag = "R8";
      if (k == 2'd0) access(0, 0, TBL[i][31:16]);
      else if (k == 2'd1) access(1, 0, TBL[i][31:16]);
      else begin
        access(1, 1, 16'h0);
        check(tag, TBL[i][15:0]);
      end
    end
    done = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule